// File: doc/BRIEF.md
# Atomic Bit-Clear Execution Unit

This unit executes one atomic bit-clear instruction at a time. The pipeline hands it a 32-bit instruction word through a valid/ready handshake. In the same cycle it supplies the value of the mask register, the value of the base register and the current stack pointer. The unit checks the fixed opcode bits and picks the access width from one size bit. It then forms and validates the address and runs a locked read-modify-write on a synchronous memory port. The memory receives the old value with the mask bits cleared. The old value, as it stood before the change, goes back to the destination register.

Register index 31 has two meanings. As the base it selects the stack pointer, which must be 16-byte aligned. As the destination it means "discard": the memory update still happens, but no register is written. A bad opcode or a misaligned address ends the instruction with a one-cycle fault and a code, with no memory or register activity. Condition flags are not touched, and the unit has no port for them.

Top module: `atomic_clr_unit`

## Requirements
- R1: An instruction is legal only when bit 31 = 1, bits [29:21] = 9'b111000001 and bits [15:10] = 6'b000100. Bit 30 selects the width: 0 for a 32-bit word, 1 for a 64-bit doubleword. The mask register index is in [20:16], the base index in [9:5] and the destination index in [4:0]. Examples: 0xB8201000 is the word form and 0xF8201000 is the doubleword form.
- R2: An illegal instruction produces exactly one cycle of `fault` with `fault_code` = 2'b01. It makes no memory request and no register write.
- R3: When the base index is not 31, the access address is `rn_data`. When it is 31, the address is `sp_value`.
- R4: When the base index is 31 and `sp_value[3:0]` is not zero, the unit faults with `fault_code` = 2'b10 and makes no memory access.
- R5: A word access needs address bits [1:0] = 0 and a doubleword access needs bits [2:0] = 0. Otherwise the unit faults with `fault_code` = 2'b11 and makes no memory access. An illegal opcode takes priority over an SP fault, and an SP fault takes priority over a data fault.
- R6: A legal access performs exactly one read request and then exactly one write request to the same address. `mem_lock` is high from the read request until the write is granted. A request whose grant is low keeps its address and direction in the next cycle.
- R7: The written value is the old value AND NOT the mask, at the access width. `mem_size` is 1 for a doubleword. For a word, the read data is taken from `mem_rdata[31:0]` and `mem_wdata[63:32]` is zero.
- R8: The old value is written to the destination register. For a word it is zero-extended, so upper read-data bits are ignored.
- R9: When the destination index is 31, no register write takes place, but the memory read-modify-write still takes place.
- R10: `instr_ready` is low from acceptance through the single `rf_we` cycle or the single `fault` cycle. `rf_we` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle; an offer is accepted |
| instr_word | input | 32 | Instruction word |
| rs_data | input | 64 | Mask register value |
| rn_data | input | 64 | Base register value |
| sp_value | input | 64 | Stack pointer value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address |
| mem_size | output | 1 | 1 = doubleword, 0 = word |
| mem_wdata | output | 64 | Write data, right-aligned |
| mem_lock | output | 1 | Memory locked for this unit |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, right-aligned |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 64 | Register write value |
| fault | output | 1 | Instruction ended in a fault |
| fault_code | output | 2 | 01 illegal, 10 SP alignment, 11 data alignment |

## Verification
The assertions assume that the memory answers a granted read with exactly one `mem_rvalid` at least one cycle after the grant. They also assume that the mask value offered at acceptance is the one the write must respect. The bench memory model follows these rules: it grants randomly, returns read data one or two cycles after a read grant, and never raises `mem_rvalid` otherwise. Stimulus keeps valid addresses inside a 128-byte model window. It mixes aligned and misaligned bases, stack-pointer bases, destination 31 and corrupted opcodes. Word reads return random upper bits so that zero-extension is exercised.

// File: rtl/atomic_clr_pkg.sv
package atomic_clr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT_RD, ST_WRITE, ST_WB, ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic       legal;
    logic       dword;
    logic [4:0] rs;
    logic [4:0] rn;
    logic [4:0] rt;
  } dec_t;

  localparam logic [1:0] FLT_NONE    = 2'b00;
  localparam logic [1:0] FLT_ILLEGAL = 2'b01;
  localparam logic [1:0] FLT_SP      = 2'b10;
  localparam logic [1:0] FLT_DATA    = 2'b11;
  localparam logic [4:0] REG_ZR_SP   = 5'd31;
endpackage

// File: rtl/atomic_clr_decode.sv
module atomic_clr_decode
  import atomic_clr_pkg::*;
(
  input  logic [31:0] instr_word,
  output dec_t        dec
);
  localparam logic [8:0] HI_FIXED = 9'b111000001;
  localparam logic [5:0] MID_FIXED = 6'b000100;

  always_comb begin
    dec.legal = instr_word[31] && (instr_word[29:21] == HI_FIXED)
                && (instr_word[15:10] == MID_FIXED);
    dec.dword = instr_word[30];
    dec.rs    = instr_word[20:16];
    dec.rn    = instr_word[9:5];
    dec.rt    = instr_word[4:0];
  end
endmodule

// File: rtl/atomic_clr_agen.sv
module atomic_clr_agen
  import atomic_clr_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] rn_data,
  input  logic [ADDR_W-1:0] sp_value,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        fault_code
);
  localparam int WORD_LOG2  = 2;
  localparam int DWORD_LOG2 = 3;

  logic use_sp;
  logic sp_bad;
  logic data_bad;

  assign use_sp = (dec.rn == REG_ZR_SP);
  assign addr   = use_sp ? sp_value : rn_data;
  assign sp_bad = use_sp && (sp_value[SP_ALIGN_LOG2-1:0] != '0);
  assign data_bad = dec.dword ? (addr[DWORD_LOG2-1:0] != '0)
                              : (addr[WORD_LOG2-1:0] != '0);

  always_comb begin
    if (!dec.legal)    fault_code = FLT_ILLEGAL;
    else if (sp_bad)   fault_code = FLT_SP;
    else if (data_bad) fault_code = FLT_DATA;
    else               fault_code = FLT_NONE;
  end
endmodule

// File: rtl/atomic_clr_seq.sv
module atomic_clr_seq
  import atomic_clr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] agen_addr,
  input  logic [1:0]        agen_fault,
  input  logic [DATA_W-1:0] rs_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_lock,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              fault,
  output logic [1:0]        fault_code
);
  localparam int HALF_W = DATA_W / 2;

  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] new_q;
  logic              dword_q;
  logic [4:0]        rt_q;
  logic [1:0]        code_q;
  logic [DATA_W-1:0] rd_ext;
  logic [DATA_W-1:0] rd_clr;

  // read data at access width, then the cleared value
  assign rd_ext = dword_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
  assign rd_clr = rd_ext & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      old_q   <= '0;
      new_q   <= '0;
      dword_q <= 1'b0;
      rt_q    <= '0;
      code_q  <= FLT_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (instr_valid) begin
            addr_q  <= agen_addr;
            dword_q <= dec.dword;
            rt_q    <= dec.rt;
            mask_q  <= dec.dword ? rs_data : {{HALF_W{1'b0}}, rs_data[HALF_W-1:0]};
            code_q  <= agen_fault;
            state   <= (agen_fault != FLT_NONE) ? ST_FAULT : ST_READ;
          end
        end
        ST_READ:    if (mem_gnt) state <= ST_WAIT_RD;
        ST_WAIT_RD: begin
          if (mem_rvalid) begin
            old_q <= rd_ext;
            new_q <= rd_clr;
            state <= ST_WRITE;
          end
        end
        ST_WRITE:   if (mem_gnt) state <= ST_WB;
        ST_WB:      state <= ST_IDLE;
        ST_FAULT: begin
          code_q <= FLT_NONE;
          state  <= ST_IDLE;
        end
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign instr_ready = (state == ST_IDLE);
  assign mem_req     = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we      = (state == ST_WRITE);
  assign mem_lock    = (state == ST_READ) || (state == ST_WAIT_RD) || (state == ST_WRITE);
  assign mem_addr    = addr_q;
  assign mem_size    = dword_q;
  assign mem_wdata   = new_q;
  assign rf_we       = (state == ST_WB) && (rt_q != REG_ZR_SP);
  assign rf_waddr    = rt_q;
  assign rf_wdata    = old_q;
  assign fault       = (state == ST_FAULT);
  assign fault_code  = fault ? code_q : FLT_NONE;
endmodule

// File: rtl/atomic_clr_unit.sv
module atomic_clr_unit
  import atomic_clr_pkg::*;
#(
  parameter int DATA_W        = 64,
  parameter int ADDR_W        = 64,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  input  logic [DATA_W-1:0] rs_data,
  input  logic [ADDR_W-1:0] rn_data,
  input  logic [ADDR_W-1:0] sp_value,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_lock,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              fault,
  output logic [1:0]        fault_code
);
  dec_t              dec;
  logic [ADDR_W-1:0] agen_addr;
  logic [1:0]        agen_fault;

  atomic_clr_decode u_dec (
    .instr_word (instr_word),
    .dec        (dec)
  );

  atomic_clr_agen #(
    .ADDR_W        (ADDR_W),
    .SP_ALIGN_LOG2 (SP_ALIGN_LOG2)
  ) u_agen (
    .dec        (dec),
    .rn_data    (rn_data),
    .sp_value   (sp_value),
    .addr       (agen_addr),
    .fault_code (agen_fault)
  );

  atomic_clr_seq #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .dec         (dec),
    .agen_addr   (agen_addr),
    .agen_fault  (agen_fault),
    .rs_data     (rs_data),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_wdata   (mem_wdata),
    .mem_lock    (mem_lock),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .rf_wdata    (rf_wdata),
    .fault       (fault),
    .fault_code  (fault_code)
  );
endmodule

// File: rtl/atomic_clr_chk.sv
module atomic_clr_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [DATA_W-1:0] rs_data,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_size,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_lock,
  input logic              mem_gnt,
  input logic              rf_we,
  input logic [4:0]        rf_waddr,
  input logic [DATA_W-1:0] rf_wdata,
  input logic              fault
);
  logic [DATA_W-1:0] mask_seen;

  always_ff @(posedge clk) begin
    if (rst) mask_seen <= '0;
    else if (instr_valid && instr_ready) mask_seen <= rs_data;
  end

  p_lock_on_req_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_lock);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_clear_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wdata & mask_seen) == '0));
  p_word_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_size) |-> (mem_wdata[DATA_W-1:DATA_W/2] == '0));
  p_zext_r8: assert property (@(posedge clk) disable iff (rst)
    (rf_we && !mem_size) |-> (rf_wdata[DATA_W-1:DATA_W/2] == '0));
  p_no_zr_write_r9: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != 5'd31));
  p_fault_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!mem_req && !rf_we && !instr_ready));
  p_we_busy_r10: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !instr_ready);
  p_we_single_r10: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);
endmodule

bind atomic_clr_unit atomic_clr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .rs_data     (rs_data),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_size    (mem_size),
  .mem_wdata   (mem_wdata),
  .mem_lock    (mem_lock),
  .mem_gnt     (mem_gnt),
  .rf_we       (rf_we),
  .rf_waddr    (rf_waddr),
  .rf_wdata    (rf_wdata),
  .fault       (fault)
);

// File: tb/atomic_clr_unit_tb.sv
module atomic_clr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic [63:0] rs_data = '0, rn_data = '0, sp_value = '0;
  logic        mem_req, mem_we, mem_size, mem_lock;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rf_we, fault;
  logic [4:0]  rf_waddr;
  logic [63:0] rf_wdata;
  logic [1:0]  fault_code;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [32];
  int rd_wait = 0, rd_idx = 0, wr_cnt = 0, rd_cnt = 0;
  logic rd_size = 1'b0;
  logic [63:0] last_waddr = '0;

  atomic_clr_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .rs_data(rs_data), .rn_data(rn_data), .sp_value(sp_value),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_lock(mem_lock), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .fault(fault), .fault_code(fault_code)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random grant, read data 1..2 cycles after a read grant
  always @(negedge clk) begin
    cycles++;
    mem_rvalid = 1'b0;
    if (rd_wait > 0) begin
      rd_wait--;
      if (rd_wait == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_size ? {mem[rd_idx+1], mem[rd_idx]} : {$urandom(), mem[rd_idx]};
      end
    end
    mem_gnt = 1'b0;
    if (!rst && mem_req && ($urandom_range(2) != 0)) begin
      mem_gnt = 1'b1;
      if (!mem_we) begin
        rd_cnt++;
        rd_wait = 1 + int'($urandom_range(1));
        rd_idx  = int'(mem_addr[6:2]);
        rd_size = mem_size;
      end else begin
        wr_cnt++;
        last_waddr = mem_addr;
        mem[mem_addr[6:2]] = mem_wdata[31:0];
        if (mem_size) mem[mem_addr[6:2] + 5'd1] = mem_wdata[63:32];
      end
    end
  end

  function automatic logic [1:0] exp_fault(logic [31:0] w, logic [63:0] rn, logic [63:0] sp);
    logic [63:0] a;
    if (!(w[31] && w[29:21] == 9'b111000001 && w[15:10] == 6'b000100)) return 2'b01;
    if (w[9:5] == 5'd31 && sp[3:0] != 4'd0) return 2'b10;
    a = (w[9:5] == 5'd31) ? sp : rn;
    if (w[30] ? (a[2:0] != 3'd0) : (a[1:0] != 2'd0)) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [31:0] mk_word(bit dw, logic [4:0] rs, logic [4:0] rn, logic [4:0] rt);
    return (dw ? 32'hF8201000 : 32'hB8201000) | {11'd0, rs, 6'd0, rn, rt};
  endfunction

  task automatic do_op(input logic [31:0] w, input logic [63:0] rsv, input logic [63:0] rnv,
                       input logic [63:0] spv, input string tag);
    logic [1:0]  ef;
    logic [63:0] a, old_v, new_v, wdat;
    logic [31:0] snap [32];
    int idx, we_n, f_n, w0, r0, guard;
    logic [1:0] fc;
    logic [4:0] wa;
    bit lock_ok;
    ef = exp_fault(w, rnv, spv);
    a  = (w[9:5] == 5'd31) ? spv : rnv;
    idx = int'(a[6:2]);
    for (int i = 0; i < 32; i++) snap[i] = mem[i];
    old_v = w[30] ? {mem[idx+1], mem[idx]} : {32'd0, mem[idx]};
    new_v = old_v & ~(w[30] ? rsv : {32'd0, rsv[31:0]});
    w0 = wr_cnt; r0 = rd_cnt; we_n = 0; f_n = 0; fc = 2'b00; wa = '0; wdat = '0;
    lock_ok = 1'b1; guard = 0;
    @(negedge clk);
    instr_word = w; rs_data = rsv; rn_data = rnv; sp_value = spv; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    while (!instr_ready && guard < 100) begin
      if (rf_we) begin we_n++; wa = rf_waddr; wdat = rf_wdata; end
      if (fault) begin f_n++; fc = fault_code; end
      if (mem_req && !mem_lock) lock_ok = 1'b0;
      guard++;
      @(negedge clk);
    end
    check(guard < 100, {tag, " R10 completion"}, guard, 0);
    if (ef != 2'b00) begin
      check(f_n == 1 && fc == ef, {tag, " R2/R4/R5 fault code"}, {fc, 8'(f_n)}, {ef, 8'd1});
      check(wr_cnt == w0 && rd_cnt == r0, {tag, " R2 no memory access"}, wr_cnt - w0 + rd_cnt - r0, 0);
      check(we_n == 0, {tag, " R2 no register write"}, we_n, 0);
    end else begin
      check(f_n == 0, {tag, " R5 unexpected fault"}, fc, 0);
      check(wr_cnt == w0 + 1 && rd_cnt == r0 + 1 && last_waddr == a, {tag, " R3/R6 one RMW at address"}, last_waddr, a);
      check(lock_ok, {tag, " R6 lock held"}, lock_ok, 1);
      check((w[30] ? {mem[idx+1], mem[idx]} : {32'd0, mem[idx]}) == new_v, {tag, " R7 memory value"},
            w[30] ? {mem[idx+1], mem[idx]} : {32'd0, mem[idx]}, new_v);
      if (w[4:0] == 5'd31) begin
        check(we_n == 0, {tag, " R9 discard destination"}, we_n, 0);
      end else begin
        check(we_n == 1 && wa == w[4:0], {tag, " R10 single write to Rt"}, {wa, 8'(we_n)}, {w[4:0], 8'd1});
        check(wdat == old_v, {tag, " R8 old value returned"}, wdat, old_v);
      end
    end
    if (ef != 2'b00) for (int i = 0; i < 32; i++)
      if (mem[i] != snap[i]) check(1'b0, {tag, " R2 memory changed"}, mem[i], snap[i]);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A7C));
    for (int i = 0; i < 32; i++) mem[i] = $urandom();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(instr_ready && !mem_req && !rf_we && !fault && !mem_lock, "R10 reset state",
          {instr_ready, mem_req, rf_we, fault}, 4'b1000);
    // directed corner cases
    do_op(mk_word(0, 5'd2, 5'd3, 5'd4), 64'hFFFF_FFFF_0000_00F0, 64'h8000_0010, 0, "R1 word basic");
    do_op(mk_word(1, 5'd2, 5'd3, 5'd5), 64'h0F0F_0000_FFFF_0001, 64'h8000_0020, 0, "R1 dword basic");
    do_op(mk_word(1, 5'd1, 5'd31, 5'd6), 64'h1, 64'h3, 64'h8000_0040, "R3 sp base");
    do_op(mk_word(0, 5'd1, 5'd31, 5'd6), 64'h1, 64'h0, 64'h8000_0044, "R4 sp misaligned");
    do_op(mk_word(0, 5'd1, 5'd7, 5'd6), 64'h1, 64'h8000_0002, 0, "R5 word misaligned");
    do_op(mk_word(1, 5'd1, 5'd7, 5'd6), 64'h1, 64'h8000_0004, 0, "R5 dword misaligned");
    do_op(mk_word(0, 5'd1, 5'd7, 5'd31), 64'hFF, 64'h8000_0008, 0, "R9 rt31");
    do_op(mk_word(0, 5'd1, 5'd7, 5'd6) ^ 32'h0000_0400, 64'h1, 64'h8000_0008, 0, "R2 illegal");
    do_op(mk_word(0, 5'd1, 5'd31, 5'd6) ^ 32'h0800_0000, 64'h1, 0, 64'h8000_0043, "R5 priority illegal");
    // constrained random
    for (int n = 0; n < 120; n++) begin
      logic [4:0] rn, rt;
      logic [63:0] rnv, spv;
      logic [31:0] w;
      bit dw;
      dw  = $urandom_range(1) != 0;
      rn  = ($urandom_range(4) == 0) ? 5'd31 : 5'($urandom_range(30));
      rt  = ($urandom_range(5) == 0) ? 5'd31 : 5'($urandom_range(30));
      rnv = 64'h8000_0000 + (dw ? 64'($urandom_range(14)) * 8 : 64'($urandom_range(31)) * 4);
      spv = 64'h8000_0000 + 64'($urandom_range(7)) * 16;
      if ($urandom_range(7) == 0) rnv[1:0] = 2'($urandom_range(3));
      if ($urandom_range(7) == 0) spv[3:0] = 4'($urandom_range(15));
      w = mk_word(dw, 5'($urandom_range(31)), rn, rt);
      if ($urandom_range(9) == 0) w = w ^ (32'd1 << (10 + $urandom_range(5)));
      do_op(w, {$urandom(), $urandom()}, rnv, spv, "R7 random");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule